// File: doc/BRIEF.md
# Interrupting Character Receive Port

This block is a memory-mapped receive port for a small 16-bit microprocessor bus. An external source, such as a keyboard front end, delivers one 8-bit ASCII character at a time as a single-cycle strobe that carries a data byte. The port stores the character and raises an active-high interrupt request. The request drives the level-2 input of the system's interrupt priority encoder.

The processor services the request by reading the port. A read returns the stored character on the low byte lane, bits 7 to 0, and also withdraws the request. No separate status or acknowledge register exists. The data read is the only way to acknowledge the interrupt. The port is selected when address bit 23 is high, which gives a base address of 0x800000. A synchronous reset clears the port. The processor's reset output may also drive that reset.

Top module: `char_in_port`

## Requirements
- R1: A synchronous reset clears the stored character to 0x00 and drops the interrupt request. After reset, a selected read returns 0x00 and the request stays low.
- R2: A character strobe captures the data byte at that clock edge. A later selected read, with address bit 23 high and the read strobe high, presents that byte on the 8-bit data output.
- R3: The interrupt request goes high in the cycle after a character strobe. It stays high for as long as the character has not been read.
- R4: A selected read lowers the interrupt request at the clock edge that ends the read cycle, unless a new character strobe arrives at that same edge.
- R5: The data output is 0x00 whenever the read strobe is low or address bit 23 is low. A read with bit 23 low does not clear the interrupt request.
- R6: A character that arrives before the previous one is read replaces it, and the interrupt request stays high.
- R7: When a selected read and a character strobe occur in the same cycle, the read returns the previously stored byte. After that edge the new byte is stored and the request is high.
- R8: A selected read with no character pending returns the last stored byte. The request stays low.
- R9: Address bits other than bit 23 are ignored. Reads at 0x800000 and at 0xFFFFFF both select the port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 24 | Processor address bus |
| busRead | input | 1 | Read strobe for the current bus cycle |
| busDataOut | output | 8 | Read data on the low byte lane, zero when the port is not being read |
| charStrobe | input | 1 | Single-cycle strobe marking a new character |
| charData | input | 8 | ASCII character that accompanies the strobe |
| irqReq | output | 1 | Active-high interrupt request, level 2 |

## Verification
The capture-and-read path is tried with several patterns:
- A single character that is read once. This separates the timing of the request's rise from the timing of its fall.
- Two characters that arrive back to back before a read. This shows that the byte is replaced rather than queued or kept.
- A strobe that arrives in the same cycle as a read. This exposes which of the two updates wins at that edge.
- Reads with bit 23 low, reads with the strobe low, and a read at the top of the address range. These separate the address decode from the read gating.
- A repeated read and a reset in the middle of the run. These show that only a strobe sets the request, and that a reset clears both the byte and the request.

// File: rtl/char_in_pkg.sv
package char_in_pkg;
  // Strobes that the control half hands to the datapath each cycle.
  typedef struct packed {
    logic loadChar;   // capture the incoming byte
    logic driveOut;   // place the held byte on the bus
  } portStrobes_t;
endpackage

// File: rtl/char_in_ctrl.sv
module char_in_ctrl #(
  parameter int ADDR_W  = 24,
  parameter int SEL_BIT = 23
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      busRead,
  input  logic                      charStrobe,
  output char_in_pkg::portStrobes_t strb,
  output logic                      irqReq
);
  logic selHit;
  logic irqNext;

  assign selHit = busAddr[SEL_BIT] & busRead;

  always_comb begin
    strb.loadChar = charStrobe;
    strb.driveOut = selHit;
    // A new arrival outranks the read-side clear.
    if (charStrobe)      irqNext = 1'b1;
    else if (selHit)     irqNext = 1'b0;
    else                 irqNext = irqReq;
  end

  always_ff @(posedge clk) begin
    if (rst) irqReq <= 1'b0;
    else     irqReq <= irqNext;
  end
endmodule

// File: rtl/char_in_data.sv
module char_in_data #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  char_in_pkg::portStrobes_t strb,
  input  logic [DATA_W-1:0]         charData,
  output logic [DATA_W-1:0]         busDataOut
);
  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (rst)               holdReg <= '0;
    else if (strb.loadChar) holdReg <= charData;
  end

  assign busDataOut = strb.driveOut ? holdReg : '0;
endmodule

// File: rtl/char_in_port.sv
module char_in_port #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 24,
  parameter int SEL_BIT = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  output logic [DATA_W-1:0] busDataOut,
  input  logic              charStrobe,
  input  logic [DATA_W-1:0] charData,
  output logic              irqReq
);
  char_in_pkg::portStrobes_t strb;

  char_in_ctrl #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busRead(busRead),
    .charStrobe(charStrobe), .strb(strb), .irqReq(irqReq)
  );

  char_in_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .charData(charData),
    .busDataOut(busDataOut)
  );
endmodule

// File: rtl/char_in_port_chk.sv
module char_in_port_chk #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 24,
  parameter int SEL_BIT = ADDR_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRead,
  input logic [DATA_W-1:0] busDataOut,
  input logic              charStrobe,
  input logic [DATA_W-1:0] charData,
  input logic              irqReq
);
  logic hit;
  assign hit = busAddr[SEL_BIT] && busRead;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!irqReq && (!hit || busDataOut == '0)));

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (charStrobe && !rst) |=> (!hit || busDataOut == $past(charData)));

  assert_irq_rise_R3: assert property (@(posedge clk) disable iff (rst)
    charStrobe |=> irqReq);

  assert_irq_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && !charStrobe) |=> !irqReq);

  assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (rst)
    !hit |-> busDataOut == '0);

  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (irqReq && !hit) |=> irqReq);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    (!irqReq && !charStrobe) |=> !irqReq);
endmodule

bind char_in_port char_in_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busRead(busRead),
  .busDataOut(busDataOut), .charStrobe(charStrobe), .charData(charData),
  .irqReq(irqReq)
);

// File: tb/tb_char_in_port.sv
`timescale 1ns/1ps
module tb_char_in_port;
  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] busAddr;
  logic        busRead;
  logic [7:0]  busDataOut;
  logic        charStrobe;
  logic [7:0]  charData;
  logic        irqReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  char_in_port dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busRead(busRead),
    .busDataOut(busDataOut), .charStrobe(charStrobe), .charData(charData),
    .irqReq(irqReq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic putChar(input logic [7:0] c);
    charStrobe = 1'b1; charData = c;
    tick();
    charStrobe = 1'b0;
  endtask

  // Selected read of one cycle: check data inside the cycle.
  task automatic readAt(input logic [23:0] a, input logic [7:0] exp, input string req);
    busAddr = a; busRead = 1'b1;
    #1 check(req, busDataOut, exp);
    tick();
    busRead = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    check("R1 irq after reset", irqReq, 0);
    readAt(24'h800000, 8'h00, "R1 data after reset");
    check("R1 irq after read", irqReq, 0);
  endtask

  task automatic t_capture();
    putChar(8'h41);
    check("R3 irq rise", irqReq, 1);
    tick(); tick(); tick();
    check("R3 irq held", irqReq, 1);
    readAt(24'h800000, 8'h41, "R2 read data");
    check("R4 irq cleared", irqReq, 0);
  endtask

  task automatic t_unselected();
    putChar(8'h5A);
    readAt(24'h7FFFFF, 8'h00, "R5 bit23 low data");
    check("R5 irq kept", irqReq, 1);
    busAddr = 24'h800000; busRead = 1'b0;
    #1 check("R5 no read strobe data", busDataOut, 0);
    tick();
    readAt(24'hFFFFFF, 8'h5A, "R9 top address data");
    check("R9 irq cleared", irqReq, 0);
  endtask

  task automatic t_overwrite();
    putChar(8'h31);
    putChar(8'h32);
    check("R6 irq high", irqReq, 1);
    readAt(24'h800000, 8'h32, "R6 newest byte");
    check("R6 irq cleared", irqReq, 0);
  endtask

  task automatic t_collide();
    putChar(8'h61);
    busAddr = 24'h800000; busRead = 1'b1;
    charStrobe = 1'b1; charData = 8'h62;
    #1 check("R7 old byte returned", busDataOut, 8'h61);
    tick();
    busRead = 1'b0; charStrobe = 1'b0;
    check("R7 irq after collide", irqReq, 1);
    readAt(24'h800000, 8'h62, "R7 new byte held");
  endtask

  task automatic t_reread();
    readAt(24'h800000, 8'h62, "R8 reread data");
    check("R8 irq stays low", irqReq, 0);
  endtask

  task automatic t_midreset();
    putChar(8'h77);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 irq midreset", irqReq, 0);
    readAt(24'h800000, 8'h00, "R1 data midreset");
  endtask

  initial begin
    rst = 1'b1; busAddr = '0; busRead = 1'b0; charStrobe = 1'b0; charData = '0;
    #2;
    t_reset();
    t_capture();
    t_unselected();
    t_overwrite();
    t_collide();
    t_reread();
    t_midreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule